// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block executes one block-transfer instruction against a sixteen-entry register file. A one-cycle start pulse delivers the instruction word and the current value of the base register. The sequencer then works through the 16-bit register list. For each selected register it issues one single-word memory access over a valid/ready request channel: a store sends the register's contents, and a load writes the returned word into that register. Successive accesses step the address by one word, upward or downward.

The instruction decides three things: which end of the list is visited first, whether the address is adjusted before or after each access, and whether the final address goes back into the base register. Encodings that are not allowed are refused with an invalid status and no side effects. The block reads and writes the register file through a combinational read port and a single write port, so it sits beside the main register file of a pipeline or microcoded core. Only bits 24:0 of the instruction reach this block; condition and class decoding are done upstream.

Top module: `multi_reg_mover`

## Requirements
- R1: Instruction fields are the register list in bits 15:0 (bit k selects register k), the base register index in bits 19:16, load (1) or store (0) in bit 20, writeback in bit 21, direction in bit 23 and pre-adjust in bit 24. For a store, each selected register's value, read through rfRdIdx/rfRdData, is sent on memWdata with memWrite high; each selected register gets exactly one access and unselected registers get none.
- R2: With bit 23 set, the selected registers are visited from index 0 up to 15, and the address grows by WORD_BYTES (4) per access.
- R3: With bit 23 clear, the selected registers are visited from index 15 down to 0, and the address shrinks by WORD_BYTES per access.
- R4: With bit 24 set, the first access goes to base ±4 (the step is applied before each access). With bit 24 clear, the first access goes to the base address itself (the step is applied after each access).
- R5: Once memValid is raised, it stays high with memAddr and memWrite unchanged until a cycle in which memReady is high.
- R6: For a load, the register is written with memRdData (rfWrEn high, rfWrIdx equal to the register index) in the cycle in which memRdValid is high. The next request does not start before then.
- R7: With bit 21 set and a non-empty list, after the last transfer the base register is written with base ± 4 × (number of selected registers). This write happens in the same cycle as done, and it takes precedence over a load into the base register.
- R8: An instruction with bit 22 set, a base index of 15, or list bit 15 set raises done and invalid together for one cycle. It causes no memory request and no register write.
- R9: An empty list raises done in the cycle after start. It causes no memory request and no register write, even with bit 21 set.
- R10: A start pulse that arrives while a transfer is in progress is ignored.
- R11: After reset, done, invalid, memValid and rfWrEn are low. done is high for exactly one cycle per accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled only when idle) |
| instrWord | input | 25 | Instruction bits 24:0 |
| baseVal | input | DATA_W | Current value of the base register |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory accepts the request |
| memWrite | output | 1 | 1 = write request, 0 = read request |
| memAddr | output | DATA_W | Word address of the request |
| memWdata | output | DATA_W | Store data |
| memRdData | input | DATA_W | Load data |
| memRdValid | input | 1 | Load data valid |
| rfRdIdx | output | 4 | Register-file read index |
| rfRdData | input | DATA_W | Register-file read data |
| rfWrEn | output | 1 | Register-file write enable |
| rfWrIdx | output | 4 | Register-file write index |
| rfWrData | output | DATA_W | Register-file write data |
| done | output | 1 | One-cycle completion pulse |
| invalid | output | 1 | Instruction refused (pulses with done) |

## Verification
The bench covers all four direction and adjust combinations, and each one gives a distinct address sequence. A design that mixed up pre- and post-adjust would be off by one word from the first access, and a design that scanned the list the wrong way would pair registers with mirrored addresses. Loads that name the base register, combined with writeback, show whether the final address wins over the loaded word. Throttled ready and a start pulse sent mid-transfer expose a request that changes before acceptance, or a second instruction that gets picked up. The empty list and each of the three refused encodings must finish with exactly one done and no bus or register traffic.

// File: rtl/multi_reg_mover_pkg.sv
package multi_reg_mover_pkg;
  localparam int NREG     = 16;
  localparam int IDX_W    = $clog2(NREG);
  localparam int INSTR_W  = 25;
  localparam int BASE_LSB = 16;
  localparam int LOAD_BIT = 20;
  localparam int WB_BIT   = 21;
  localparam int BAD_BIT  = 22;
  localparam int UP_BIT   = 23;
  localparam int PRE_BIT  = 24;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_RDW, S_FIN, S_BAD} seqState_t;

  typedef struct packed {
    logic capture;
    logic advance;
    logic wrLoad;
    logic wrBase;
  } dpStrobe_t;
endpackage

// File: rtl/multi_reg_mover_dp.sv
module multi_reg_mover_dp import multi_reg_mover_pkg::*; #(
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [DATA_W-1:0]  baseVal,
  input  logic [DATA_W-1:0]  memRdData,
  input  logic [DATA_W-1:0]  rfRdData,
  output logic               badIn,
  output logic               emptyIn,
  output logic               isLoad,
  output logic               isWb,
  output logic               lastOne,
  output logic               pendEmpty,
  output logic [DATA_W-1:0]  memAddr,
  output logic               memWrite,
  output logic [DATA_W-1:0]  memWdata,
  output logic [IDX_W-1:0]   rfRdIdx,
  output logic               rfWrEn,
  output logic [IDX_W-1:0]   rfWrIdx,
  output logic [DATA_W-1:0]  rfWrData
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(WORD_BYTES);

  logic [DATA_W-1:0] addrQ;
  logic [NREG-1:0]   pendQ;
  logic              upQ, preQ, loadQ, wbQ;
  logic [IDX_W-1:0]  baseQ, ldIdxQ, curIdx;
  logic [NREG-1:0]   listIn, pendNext;
  logic [DATA_W-1:0] stepAddr;

  assign listIn  = instrWord[NREG-1:0];
  assign badIn   = instrWord[BAD_BIT] | (instrWord[BASE_LSB +: IDX_W] == IDX_W'(NREG - 1))
                 | listIn[NREG-1];
  assign emptyIn = (listIn == '0);

  // next register: lowest set bit when ascending, highest when descending
  always_comb begin
    curIdx = '0;
    if (upQ) begin
      for (int i = NREG - 1; i >= 0; i--) if (pendQ[i]) curIdx = IDX_W'(i);
    end else begin
      for (int i = 0; i < NREG; i++) if (pendQ[i]) curIdx = IDX_W'(i);
    end
  end

  assign pendNext  = pendQ & ~(NREG'(1) << curIdx);
  assign lastOne   = (pendNext == '0);
  assign pendEmpty = (pendQ == '0);
  assign stepAddr  = upQ ? addrQ + STEP : addrQ - STEP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      pendQ  <= '0;
      upQ    <= 1'b0;
      preQ   <= 1'b0;
      loadQ  <= 1'b0;
      wbQ    <= 1'b0;
      baseQ  <= '0;
      ldIdxQ <= '0;
    end else if (strobe.capture) begin
      addrQ <= baseVal;
      pendQ <= listIn;
      upQ   <= instrWord[UP_BIT];
      preQ  <= instrWord[PRE_BIT];
      loadQ <= instrWord[LOAD_BIT];
      wbQ   <= instrWord[WB_BIT] & ~emptyIn;
      baseQ <= instrWord[BASE_LSB +: IDX_W];
    end else if (strobe.advance) begin
      addrQ  <= stepAddr;
      pendQ  <= pendNext;
      ldIdxQ <= curIdx;
    end
  end

  assign isLoad   = loadQ;
  assign isWb     = wbQ;
  assign memAddr  = preQ ? stepAddr : addrQ;
  assign memWrite = ~loadQ;
  assign rfRdIdx  = curIdx;
  assign memWdata = rfRdData;
  assign rfWrEn   = strobe.wrLoad | strobe.wrBase;
  assign rfWrIdx  = strobe.wrBase ? baseQ : ldIdxQ;
  assign rfWrData = strobe.wrBase ? addrQ : memRdData;

  // R2 / R3: each accepted access moves the address one word in the scan direction
  p_step_dir_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (addrQ == (upQ ? $past(addrQ) + STEP : $past(addrQ) - STEP)));
  // R1: every accepted access retires exactly one list entry
  p_one_visit_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> ($countones(pendQ) == $countones($past(pendQ)) - 1));
endmodule

// File: rtl/multi_reg_mover_ctrl.sv
module multi_reg_mover_ctrl import multi_reg_mover_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      badIn,
  input  logic      emptyIn,
  input  logic      isLoad,
  input  logic      isWb,
  input  logic      lastOne,
  input  logic      pendEmpty,
  input  logic      memReady,
  input  logic      memRdValid,
  output dpStrobe_t strobe,
  output logic      memValid,
  output logic      done,
  output logic      invalid
);
  seqState_t stateQ, stateD;

  always_comb begin
    stateD   = stateQ;
    strobe   = '0;
    memValid = 1'b0;
    done     = 1'b0;
    invalid  = 1'b0;
    unique case (stateQ)
      S_IDLE: if (start) begin
        if (badIn) stateD = S_BAD;
        else begin
          strobe.capture = 1'b1;
          stateD = emptyIn ? S_FIN : S_REQ;
        end
      end
      S_REQ: begin
        memValid = 1'b1;
        if (memReady) begin
          strobe.advance = 1'b1;
          if (isLoad)       stateD = S_RDW;
          else if (lastOne) stateD = S_FIN;
        end
      end
      S_RDW: if (memRdValid) begin
        strobe.wrLoad = 1'b1;
        stateD = pendEmpty ? S_FIN : S_REQ;
      end
      S_FIN: begin
        done          = 1'b1;
        strobe.wrBase = isWb;
        stateD        = S_IDLE;
      end
      S_BAD: begin
        done    = 1'b1;
        invalid = 1'b1;
        stateD  = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8: a refused instruction touches neither memory nor registers
  p_bad_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    invalid |-> (done && !memValid && !strobe.wrBase && !strobe.wrLoad));
  // R10: a start seen while busy never re-captures
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != S_IDLE) |-> !strobe.capture);
endmodule

// File: rtl/multi_reg_mover.sv
module multi_reg_mover import multi_reg_mover_pkg::*; #(
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [DATA_W-1:0]  baseVal,
  output logic               memValid,
  input  logic               memReady,
  output logic               memWrite,
  output logic [DATA_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  input  logic [DATA_W-1:0]  memRdData,
  input  logic               memRdValid,
  output logic [IDX_W-1:0]   rfRdIdx,
  input  logic [DATA_W-1:0]  rfRdData,
  output logic               rfWrEn,
  output logic [IDX_W-1:0]   rfWrIdx,
  output logic [DATA_W-1:0]  rfWrData,
  output logic               done,
  output logic               invalid
);
  dpStrobe_t strobe;
  logic badIn, emptyIn, isLoad, isWb, lastOne, pendEmpty;

  multi_reg_mover_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .badIn(badIn), .emptyIn(emptyIn),
    .isLoad(isLoad), .isWb(isWb), .lastOne(lastOne), .pendEmpty(pendEmpty),
    .memReady(memReady), .memRdValid(memRdValid), .strobe(strobe),
    .memValid(memValid), .done(done), .invalid(invalid)
  );

  multi_reg_mover_dp #(.DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .instrWord(instrWord), .baseVal(baseVal),
    .memRdData(memRdData), .rfRdData(rfRdData), .badIn(badIn), .emptyIn(emptyIn),
    .isLoad(isLoad), .isWb(isWb), .lastOne(lastOne), .pendEmpty(pendEmpty),
    .memAddr(memAddr), .memWrite(memWrite), .memWdata(memWdata), .rfRdIdx(rfRdIdx),
    .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx), .rfWrData(rfWrData)
  );

  // R5: a pending request holds until accepted
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWrite)));
  // R6: no new request while a load result is outstanding
  p_rd_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady && !memWrite) |=> !memValid);
endmodule

// File: tb/multi_reg_mover_tb.sv
module multi_reg_mover_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        start = 1'b0;
  logic [24:0] instrIn = '0;
  logic [31:0] baseIn = '0;
  logic        memValid, memWrite, rfWrEn, done, invalid;
  logic [31:0] memAddr, memWdata, rfWrData, rfRdData;
  logic [3:0]  rfRdIdx, rfWrIdx;
  logic        readyQ, pendRd;
  logic [31:0] rdDataQ;
  bit          stallMode = 1'b0;

  logic [31:0] regs [16];
  logic [31:0] mem [64];
  logic [31:0] accAddr [256];
  logic        accWr [256];
  logic [31:0] accData [256];
  logic [3:0]  wrIdxLog [256];
  logic [31:0] wrDataLog [256];
  int accCnt = 0, wrCnt = 0, doneCnt = 0, invCnt = 0, holdErr = 0;
  logic        prevHold;
  logic [31:0] prevAddr;
  int checkCnt = 0, failCnt = 0;

  assign rfRdData = regs[rfRdIdx];

  multi_reg_mover u_dut (
    .clk(clk), .rstN(rstN), .start(start), .instrWord(instrIn), .baseVal(baseIn),
    .memValid(memValid), .memReady(readyQ), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memRdData(rdDataQ), .memRdValid(pendRd),
    .rfRdIdx(rfRdIdx), .rfRdData(rfRdData), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx),
    .rfWrData(rfWrData), .done(done), .invalid(invalid)
  );

  // memory, register file and traffic recorder
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) regs[i] <= 32'h80 | (32'(i) << 20);
      for (int i = 0; i < 64; i++) mem[i] <= 32'hD000_0000 | (32'(i) << 8) | 32'(i);
      pendRd   <= 1'b0;
      readyQ   <= 1'b1;
      rdDataQ  <= '0;
      prevHold <= 1'b0;
      prevAddr <= '0;
    end else begin
      readyQ <= stallMode ? ~readyQ : 1'b1;
      if (prevHold && !(memValid && memAddr == prevAddr)) holdErr <= holdErr + 1;
      prevHold <= memValid && !readyQ;
      prevAddr <= memAddr;
      if (memValid && readyQ) begin
        accAddr[accCnt & 255] <= memAddr;
        accWr[accCnt & 255]   <= memWrite;
        accData[accCnt & 255] <= memWdata;
        accCnt <= accCnt + 1;
        if (memWrite) mem[memAddr[7:2]] <= memWdata;
        else rdDataQ <= mem[memAddr[7:2]];
      end
      if (memValid && readyQ && !memWrite) pendRd <= 1'b1;
      else if (pendRd) pendRd <= 1'b0;
      if (rfWrEn) begin
        regs[rfWrIdx] <= rfWrData;
        wrIdxLog[wrCnt & 255]  <= rfWrIdx;
        wrDataLog[wrCnt & 255] <= rfWrData;
        wrCnt <= wrCnt + 1;
      end
      if (done) doneCnt <= doneCnt + 1;
      if (invalid) invCnt <= invCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [24:0] mk(input logic p, input logic u, input logic w,
                                     input logic l, input logic [3:0] b, input logic [15:0] list);
    return {p, u, 1'b0, w, l, b, list};
  endfunction

  task automatic runOp(input string tag, input logic p, input logic u, input logic w,
                       input logic l, input logic [3:0] b, input logic [15:0] list,
                       input bit stall, input bit poke);
    logic [31:0] snapR [16];
    logic [31:0] snapM [64];
    logic [31:0] expAddr [16];
    logic [3:0]  expReg [16];
    logic [31:0] a, baseV;
    int n = 0, acc0, wr0, done0, bad, expWr, t;
    bit wbExp;
    for (int i = 0; i < 16; i++) snapR[i] = regs[i];
    for (int i = 0; i < 64; i++) snapM[i] = mem[i];
    baseV = regs[b];
    a = baseV;
    for (int s = 0; s < 16; s++) begin
      int k = u ? s : 15 - s;
      if (list[k]) begin
        if (p) a = u ? a + 4 : a - 4;
        expAddr[n] = a;
        expReg[n] = 4'(k);
        if (!p) a = u ? a + 4 : a - 4;
        n++;
      end
    end
    wbExp = w && (n > 0);
    expWr = (l ? n : 0) + (wbExp ? 1 : 0);
    acc0 = accCnt; wr0 = wrCnt; done0 = doneCnt;
    stallMode = stall;
    @(negedge clk);
    instrIn = mk(p, u, w, l, b, list);
    baseIn = baseV;
    start = 1'b1;
    @(negedge clk);
    if (poke) begin
      instrIn = mk(1'b0, 1'b1, 1'b1, 1'b0, 4'd2, 16'h000F);
      baseIn = 32'h0;
      @(negedge clk);
      @(negedge clk);
    end
    start = 1'b0;
    t = 0;
    while (doneCnt == done0 && t < 400) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    chk(doneCnt - done0 == 1, "R11", {tag, " done pulses"}, 32'(doneCnt - done0), 1);
    chk(accCnt - acc0 == n, "R1", {tag, " access count"}, 32'(accCnt - acc0), 32'(n));
    bad = 0;
    for (int j = 0; j < n && j < accCnt - acc0; j++)
      if (accAddr[(acc0 + j) & 255] !== expAddr[j] || accWr[(acc0 + j) & 255] !== !l) begin
        if (bad == 0)
          chk(1'b0, tag, "address order", accAddr[(acc0 + j) & 255], expAddr[j]);
        bad++;
      end
    if (bad == 0) chk(1'b1, tag, "address order", 0, 0);
    if (!l) begin
      bad = 0;
      for (int j = 0; j < n && j < accCnt - acc0; j++)
        if (accData[(acc0 + j) & 255] !== snapR[expReg[j]]) begin
          if (bad == 0)
            chk(1'b0, "R1", {tag, " store data"}, accData[(acc0 + j) & 255], snapR[expReg[j]]);
          bad++;
        end
      if (bad == 0) chk(1'b1, "R1", {tag, " store data"}, 0, 0);
    end
    chk(wrCnt - wr0 == expWr, "R6/R7", {tag, " register writes"}, 32'(wrCnt - wr0), 32'(expWr));
    if (l && wrCnt - wr0 == expWr) begin
      bad = 0;
      for (int j = 0; j < n; j++)
        if (wrIdxLog[(wr0 + j) & 255] !== expReg[j] ||
            wrDataLog[(wr0 + j) & 255] !== snapM[expAddr[j][7:2]]) begin
          if (bad == 0)
            chk(1'b0, "R6", {tag, " load data"}, wrDataLog[(wr0 + j) & 255], snapM[expAddr[j][7:2]]);
          bad++;
        end
      if (bad == 0) chk(1'b1, "R6", {tag, " load data"}, 0, 0);
    end
    if (wbExp)
      chk(regs[b] === a, "R7", {tag, " writeback"}, regs[b], a);
    else if (!(l && list[b]))
      chk(regs[b] === baseV, "R7/R9", {tag, " base untouched"}, regs[b], baseV);
    chk(holdErr == 0, "R5", {tag, " request held"}, 32'(holdErr), 0);
  endtask

  task automatic runBad(input string what, input logic [24:0] instr);
    int acc0 = accCnt, wr0 = wrCnt, d0 = doneCnt, i0 = invCnt;
    @(negedge clk);
    instrIn = instr;
    baseIn = 32'h80;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(invCnt - i0 == 1, "R8", {what, " invalid pulse"}, 32'(invCnt - i0), 1);
    chk(doneCnt - d0 == 1, "R8", {what, " done pulse"}, 32'(doneCnt - d0), 1);
    chk(accCnt == acc0 && wrCnt == wr0, "R8", {what, " no traffic"},
        32'(accCnt - acc0 + wrCnt - wr0), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !invalid && !memValid && !rfWrEn, "R11", "reset outputs",
        {28'd0, done, invalid, memValid, rfWrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // store, ascending, post-adjust, writeback
    runOp("R2 R4 store up post", 1'b0, 1'b1, 1'b1, 1'b0, 4'd3, 16'h00F5, 1'b0, 1'b0);
    // store, descending, pre-adjust, writeback, throttled ready
    runOp("R3 R4 store down pre", 1'b1, 1'b0, 1'b1, 1'b0, 4'd4, 16'h7A13, 1'b1, 1'b0);
    // load, ascending, pre-adjust, base in list without writeback
    runOp("R2 R6 load up pre", 1'b1, 1'b1, 1'b0, 1'b1, 4'd5, 16'h0161, 1'b1, 1'b0);
    // load, descending, post-adjust, base in list with writeback
    runOp("R3 R7 load down post", 1'b0, 1'b0, 1'b1, 1'b1, 4'd6, 16'h40C2, 1'b0, 1'b0);
    // single register, descending, pre-adjust
    runOp("R3 R4 single", 1'b1, 1'b0, 1'b1, 1'b0, 4'd7, 16'h4000, 1'b0, 1'b0);
    // empty list with writeback requested
    runOp("R9 empty", 1'b0, 1'b1, 1'b1, 1'b0, 4'd8, 16'h0000, 1'b0, 1'b0);
    // start pulses while busy
    runOp("R10 busy start", 1'b0, 1'b1, 1'b1, 1'b0, 4'd9, 16'h0F00, 1'b1, 1'b1);
    runBad("R8 bit22", 25'h040_0003);
    runBad("R8 base15", mk(1'b0, 1'b1, 1'b0, 1'b0, 4'd15, 16'h0003));
    runBad("R8 list15", mk(1'b0, 1'b1, 1'b0, 1'b1, 4'd1, 16'h8001));
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt + 1);
    $finish;
  end
endmodule